// File: doc/BRIEF.md
# Byte-Register Indirect Bus Bridge

This bridge lets a host with nothing more than a narrow byte-wide register port run single-beat transactions on a 32-bit internal bus. The host loads the target address and, for a write, the payload into small byte registers. It picks an access size and then starts the transaction as a side effect of one control register. Writing a fixed key value to that register launches a bus write. Reading the same register launches a bus read. When a read completes, its result is captured into byte registers that the host can read back one at a time.

Multi-byte fields are laid out most significant byte first. A status register shows whether a transaction is still outstanding. Triggers that arrive while the bridge is disabled or busy are dropped. The register index values below are part of the host's programming model and are fixed.

On the bus side the bridge acts as a master with a request/acknowledge handshake. It raises `bus_req` with address, data, direction and size, and holds all of them unchanged until the responder returns `bus_done`. The bridge takes the acknowledge in the same clock in which `bus_done` is high, and `bus_req` falls on the next edge. The responder applies back-pressure simply by keeping `bus_done` low for as long as it needs. There is no limit on the wait.

Top module: `bytereg_bus_bridge`

## Requirements
- R1: After reset the enable bit, the address bytes, the data bytes, the size code and the captured read data all read as 0, and `bus_req` is low.
- R2: Bit 0 of register 0x30 is the enable and reads back as {7'b0, enable}. While it is 0, neither trigger starts a transaction.
- R3: Registers 0xF0, 0xF1, 0xF2 and 0xF3 hold address bits [31:24], [23:16], [15:8] and [7:0]. They read back as written, and the transaction address is assembled from them in that order.
- R4: A host write of 0xCF to register 0xFE, while enabled and idle, raises `bus_req` at the next clock edge with `bus_we`=1. A write of any other value to 0xFE has no effect.
- R5: A host read of register 0xFE, while enabled and idle, raises `bus_req` at the next clock edge with `bus_we`=0. Reading 0xFE returns 0.
- R6: While `bus_req` is high and `bus_done` is low, `bus_req`, `bus_addr`, `bus_wdata`, `bus_we` and `bus_size` stay unchanged. `bus_req` falls at the edge after `bus_done` is seen high. `bus_done` has no effect while no request is outstanding.
- R7: Register 0xF8 holds a size code that reads back raw. `bus_size` is 0 for code 0 (1 byte), 1 for code 1 (2 bytes) and 2 for any code of 2 or above (4 bytes). Write data comes from 0xF4 (bits [31:24]) down to 0xF7 (bits [7:0]), and for narrow sizes only the low 1 or 2 bytes are driven, with the upper bytes zero.
- R8: When a read completes, `bus_rdata` is captured with 0xF4 returning bits [31:24] down to 0xF7 returning bits [7:0]. For 1-byte and 2-byte reads the bytes above the access size are captured as zero. Completion of a write leaves the captured data unchanged.
- R9: Host reads of 0xF4 to 0xF7 return the captured read data, not the values the host wrote there, and keep returning it until another read completes.
- R10: Bit 0 of register 0xF9 is 1 while a transaction is outstanding. Triggers that arrive while busy are dropped. Host register writes made while busy do not alter the transaction on the bus.
- R11: `reg_rdata` shows, in the same cycle, the register selected by `reg_idx`. Indexes with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 8 | Register index for host accesses |
| reg_wdata | input | 8 | Host write byte |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_rd | input | 1 | Host read strobe, one cycle per read |
| reg_rdata | output | 8 | Contents of the selected register |
| bus_req | output | 1 | Transaction outstanding |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Write data, narrow sizes in the low lanes |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_size | output | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_done | input | 1 | Responder acknowledge; completes the transaction |
| bus_rdata | input | 32 | Read data, valid with bus_done |

## Verification
The hardest case to reach from the ports is a trigger or a register rewrite that lands while a transaction is still open on the bus. The stimulus creates it by starting a read and holding `bus_done` low for several cycles. During that wait it repeats the write trigger and overwrites an address byte. It then checks that the bus signals did not move and that exactly one transaction completes. A stray `bus_done` with no request open, and a write completion that must leave the captured read bytes alone, are exercised in the same way.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int IW  = 8;
  localparam int AB  = AW / 8;
  localparam int DB  = DW / 8;
  localparam int SZW = 2;

  localparam logic [IW-1:0] IDX_EN    = 8'h30;
  localparam logic [IW-1:0] IDX_ADDR0 = 8'hF0;
  localparam logic [IW-1:0] IDX_DATA0 = 8'hF4;
  localparam logic [IW-1:0] IDX_SIZE  = 8'hF8;
  localparam logic [IW-1:0] IDX_STAT  = 8'hF9;
  localparam logic [IW-1:0] IDX_GO    = 8'hFE;
  localparam logic [7:0]    WR_KEY    = 8'hCF;

  localparam logic [SZW-1:0] SZ_MAX = SZW'($clog2(DB));

  typedef struct packed {
    logic           we;
    logic [SZW-1:0] size;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  wdata;
  } bbr_txn_t;

  // clamp a raw size code to the widest supported access
  function automatic logic [SZW-1:0] norm_size(input logic [7:0] code);
    if (code > 8'(SZ_MAX)) return SZ_MAX;
    return code[SZW-1:0];
  endfunction

  // keep the low 2**sz byte lanes
  function automatic logic [DW-1:0] lane_mask(input logic [SZW-1:0] sz);
    logic [DW-1:0] m;
    int n;
    n = 1 << sz;
    for (int j = 0; j < DB; j++) m[8*j +: 8] = (j < n) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/bbr_regfile.sv
module bbr_regfile
  import bbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reg_idx,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  input  logic          busy,
  input  logic [DW-1:0] cap_data,
  output logic          en,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [7:0]    size_code,
  output logic [7:0]    rdata
);
  logic [7:0] abyte [AB];
  logic [7:0] dbyte [DB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      size_code <= 8'h00;
      for (int i = 0; i < AB; i++) abyte[i] <= 8'h00;
      for (int i = 0; i < DB; i++) dbyte[i] <= 8'h00;
    end else if (reg_wr) begin
      if (reg_idx == IDX_EN)   en        <= reg_wdata[0];
      if (reg_idx == IDX_SIZE) size_code <= reg_wdata;
      for (int i = 0; i < AB; i++)
        if (reg_idx == IDX_ADDR0 + IW'(i)) abyte[i] <= reg_wdata;
      for (int i = 0; i < DB; i++)
        if (reg_idx == IDX_DATA0 + IW'(i)) dbyte[i] <= reg_wdata;
    end
  end

  // lowest index carries the most significant byte
  for (genvar g = 0; g < AB; g++) begin : g_addr
    assign addr[AW-1-8*g -: 8] = abyte[g];
  end
  for (genvar g = 0; g < DB; g++) begin : g_wdat
    assign wdata[DW-1-8*g -: 8] = dbyte[g];
  end

  always_comb begin
    rdata = 8'h00;
    if (reg_idx == IDX_EN)   rdata = {7'b0, en};
    if (reg_idx == IDX_SIZE) rdata = size_code;
    if (reg_idx == IDX_STAT) rdata = {7'b0, busy};
    for (int i = 0; i < AB; i++)
      if (reg_idx == IDX_ADDR0 + IW'(i)) rdata = abyte[i];
    for (int i = 0; i < DB; i++)
      if (reg_idx == IDX_DATA0 + IW'(i)) rdata = cap_data[DW-1-8*i -: 8];
  end

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_idx == IDX_EN) |=> $stable(en)); // R2
endmodule

// File: rtl/bbr_trigger.sv
module bbr_trigger
  import bbr_pkg::*;
(
  input  logic [IW-1:0] reg_idx,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          en,
  input  logic          busy,
  output logic          start,
  output logic          start_we
);
  logic hit_go, wr_trig, rd_trig;

  assign hit_go   = (reg_idx == IDX_GO);
  assign wr_trig  = hit_go && reg_wr && (reg_wdata == WR_KEY);
  assign rd_trig  = hit_go && reg_rd && !reg_wr;
  assign start    = en && !busy && (wr_trig || rd_trig);
  assign start_we = wr_trig;
endmodule

// File: rtl/bbr_master.sv
module bbr_master
  import bbr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata_raw,
  input  logic [7:0]     size_code,
  input  logic           bus_done,
  input  logic [DW-1:0]  bus_rdata,
  output logic           bus_req,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  output logic           bus_we,
  output logic [SZW-1:0] bus_size,
  output logic [DW-1:0]  cap_data
);
  bbr_txn_t       txn_q;
  logic [SZW-1:0] sz_n;

  assign sz_n = norm_size(size_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txn_q    <= '0;
      bus_req  <= 1'b0;
      cap_data <= '0;
    end else if (!bus_req && start) begin
      txn_q   <= '{we: start_we, size: sz_n, addr: addr,
                   wdata: wdata_raw & lane_mask(sz_n)};
      bus_req <= 1'b1;
    end else if (bus_req && bus_done) begin
      bus_req <= 1'b0;
      if (!txn_q.we) cap_data <= bus_rdata & lane_mask(txn_q.size);
    end
  end

  assign bus_addr  = txn_q.addr;
  assign bus_wdata = txn_q.wdata;
  assign bus_we    = txn_q.we;
  assign bus_size  = txn_q.size;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req); // R6
  AST_TXN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> $stable(bus_addr) && $stable(bus_wdata)
                             && $stable(bus_we) && $stable(bus_size)); // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done |=> !bus_req); // R6
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_done && !bus_we) |=> $stable(cap_data)); // R8
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size <= SZ_MAX); // R7
  AST_NARROW_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_size == '0 |-> bus_wdata[DW-1:8] == '0); // R7
endmodule

// File: rtl/bytereg_bus_bridge.sv
module bytereg_bus_bridge
  import bbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_idx,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  output logic        bus_req,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  input  logic        bus_done,
  input  logic [31:0] bus_rdata
);
  logic          en, start, start_we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata_raw, cap_data;
  logic [7:0]    size_code;

  bbr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .busy(bus_req), .cap_data(cap_data), .en(en),
    .addr(addr), .wdata(wdata_raw), .size_code(size_code), .rdata(reg_rdata)
  );

  bbr_trigger u_trig (
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .en(en), .busy(bus_req), .start(start),
    .start_we(start_we)
  );

  bbr_master u_mst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(start_we),
    .addr(addr), .wdata_raw(wdata_raw), .size_code(size_code),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_size(bus_size), .cap_data(cap_data)
  );

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !en |=> !bus_req); // R2
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && reg_wr && !reg_rd && reg_idx == IDX_GO && reg_wdata != WR_KEY
      |=> !bus_req); // R4
endmodule

// File: tb/bytereg_bus_bridge_tb.sv
module bytereg_bus_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {we, size code, addr, wdata, responder data}
  localparam logic [104:0] VEC [NV] = '{
    {1'b1, 8'h02, 32'h3000_0010, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h02, 32'h1E78_9088, 32'h0,         32'hA1B2_C3D4},
    {1'b1, 8'h00, 32'h0000_0003, 32'h1122_3344, 32'h0},
    {1'b0, 8'h01, 32'h8000_0002, 32'h0,         32'h5566_7788},
    {1'b0, 8'h00, 32'hFFFF_FFFC, 32'h0,         32'h99AA_BBCC},
    {1'b1, 8'h07, 32'h0E00_0000, 32'hCAFE_F00D, 32'h0},
    {1'b0, 8'hFF, 32'h1234_5678, 32'h0,         32'h0BAD_C0DE},
    {1'b1, 8'h01, 32'h0000_0100, 32'h1234_5678, 32'h0}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] reg_idx = 0, reg_wdata = 0, reg_rdata;
  logic reg_wr = 0, reg_rd = 0, bus_req, bus_we, bus_done = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [1:0] bus_size;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytereg_bus_bridge u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); reg_idx = idx; reg_wdata = val; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] val);
    @(negedge clk); reg_idx = idx; reg_rd = 1; #1 val = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_cap(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'hF4 + 8'(i), b);
      v[31-8*i -: 8] = b;
    end
  endtask

  task automatic done(input logic [31:0] d);
    @(negedge clk); bus_done = 1; bus_rdata = d;
    @(negedge clk); bus_done = 0;
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] d, input logic [7:0] sz);
    for (int i = 0; i < 4; i++) wr(8'hF0 + 8'(i), a[31-8*i -: 8]);
    for (int i = 0; i < 4; i++) wr(8'hF4 + 8'(i), d[31-8*i -: 8]);
    wr(8'hF8, sz);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 bus_req", {31'b0, bus_req}, 0);
    rd(8'h30, b); check("R1 enable", {24'b0, b}, 0);
    rd(8'hF0, b); check("R1 addr", {24'b0, b}, 0);
    rd(8'hF8, b); check("R1 size", {24'b0, b}, 0);
    rd_cap(v);    check("R1 capture", v, 0);

    // R2 disabled triggers dropped
    load(32'h1, 32'h2, 8'h02);
    wr(8'hFE, 8'hCF); check("R2 write trigger disabled", {31'b0, bus_req}, 0);
    rd(8'hFE, b);     check("R2 read trigger disabled", {31'b0, bus_req}, 0);
    wr(8'h30, 8'h01);
    rd(8'h30, b); check("R2 enable readback", {24'b0, b}, 1);

    // R4 wrong key
    wr(8'hFE, 8'hCE); check("R4 wrong key ignored", {31'b0, bus_req}, 0);
    // R11 unmapped and trigger register
    rd(8'h55, b); check("R11 unmapped reads 0", {24'b0, b}, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic we; logic [7:0] code; logic [31:0] a, d, r, m; logic [1:0] es;
      {we, code, a, d, r} = VEC[k];
      es = (code > 2) ? 2'd2 : code[1:0];
      m  = (es == 0) ? 32'hFF : (es == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      load(a, d, code);
      rd(8'hF0, b); check("R3 addr byte msb", {24'b0, b}, {24'b0, a[31:24]});
      rd(8'hF3, b); check("R3 addr byte lsb", {24'b0, b}, {24'b0, a[7:0]});
      rd(8'hF8, b); check("R7 size raw", {24'b0, b}, {24'b0, code});
      if (we) wr(8'hFE, 8'hCF);
      else begin
        rd(8'hFE, b); check("R5 trigger reads 0", {24'b0, b}, 0);
      end
      check(we ? "R4 req" : "R5 req", {31'b0, bus_req}, 1);
      check(we ? "R4 we" : "R5 we", {31'b0, bus_we}, {31'b0, we});
      check("R3 bus_addr", bus_addr, a);
      check("R7 bus_size", {30'b0, bus_size}, {30'b0, es});
      if (we) check("R7 bus_wdata", bus_wdata, d & m);
      rd(8'hF9, b); check("R10 busy bit", {24'b0, b}, 1);
      done(r);
      check("R6 req released", {31'b0, bus_req}, 0);
      if (!we) exp_cap = r & m;
      rd_cap(v); check("R8 capture", v, exp_cap);
    end

    // R9 host writes to data regs do not show in readback
    wr(8'hF4, 8'h5A);
    rd(8'hF4, b); check("R9 capture not host data", {24'b0, b}, {24'b0, exp_cap[31:24]});

    // R6 stray done while idle
    done(32'hFFFF_FFFF);
    check("R6 idle done no req", {31'b0, bus_req}, 0);
    rd_cap(v); check("R6 idle done no capture", v, exp_cap);

    // R10 activity while busy
    load(32'hA000_0004, 32'h0, 8'h02);
    rd(8'hFE, b);
    repeat (3) @(negedge clk);
    check("R6 held without done", {31'b0, bus_req}, 1);
    wr(8'hFE, 8'hCF);
    wr(8'hF0, 8'h77);
    check("R10 we unchanged", {31'b0, bus_we}, 0);
    check("R10 addr unchanged", bus_addr, 32'hA000_0004);
    done(32'h1357_9BDF);
    exp_cap = 32'h1357_9BDF;
    repeat (2) @(negedge clk);
    check("R10 dropped trigger", {31'b0, bus_req}, 0);
    rd_cap(v); check("R8 capture after busy", v, exp_cap);

    summary();
  end
endmodule